// File: doc/BRIEF.md
# Power-Up Serial Boot Loader

This block runs once after every reset. Before the processor is allowed to execute, the block asks for the processor bus and waits until the processor grants it. It then receives a fixed number of bytes from an asynchronous serial line and writes them into memory one at a time, starting at address zero and counting up. Once the last byte has been stored, the block drops its bus request and turns off all of its bus drivers. The processor then starts from address zero exactly as it would after a normal reset, and runs the program that was just loaded.

After the hand-off the serial line is no longer a load path. The same receiver and a small transmitter are then reached through a two-register port in the processor's address space. One register holds received and transmitted data, and the other holds the ready flags. The receiver oversamples the line at sixteen times the bit rate. It is clocked by a divided tick, and the divider is a parameter, so the bit rate follows from the clock.

Top module: `serial_boot_loader`

## Requirements
- R1: From reset, `bus_req_o` is high. `dma_drive_o`, `dma_as_o` and `dma_we_o` stay low until `bus_grant_i` has been seen high.
- R2: While the block owns the bus, `dma_drive_o` and `dma_as_o` are high. Each accepted serial byte produces exactly one write strobe (`dma_we_o` high for one cycle) that carries that byte on `dma_data_o`.
- R3: Load writes go to addresses 0, 1, 2, ... in order, one address higher per byte.
- R4: After exactly LOAD_BYTES writes (default 255, addresses 0 to 254), `bus_req_o` and `dma_drive_o` fall and stay low until the next reset. No further memory writes follow, whatever arrives on the serial line.
- R5: Serial bytes that are completed before the bus has been granted are discarded. They are neither written nor counted.
- R6: The serial format is 8 data bits sent LSB first, no parity and one stop bit, with the line idle high. Each bit is sampled at the middle of its 16 oversample ticks. A frame whose stop bit is low is discarded and not counted.
- R7: Register port: the data register is at 0xFFFFF000 and the status register is at 0xFFFFF001, where bit 0 = transmitter empty and bit 1 = received byte ready. Read data appears on `cpu_rdata_o` in the cycle after the select. After the hand-off, a received byte sets the ready flag and can be read from the data register.
- R8: Reading the data register clears the received-byte-ready flag.
- R9: Writing the data register while the transmitter is empty sends the byte on `tx_o` in the R6 format. Transmitter-empty reads 0 from the cycle after the write until the stop bit has been sent. A write made while the transmitter is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| bus_req_o | output | 1 | Bus request to the processor |
| bus_grant_i | input | 1 | Bus grant from the processor |
| dma_drive_o | output | 1 | Loader bus drivers enabled |
| dma_as_o | output | 1 | Loader address strobe |
| dma_we_o | output | 1 | Loader one-cycle memory write strobe |
| dma_addr_o | output | ADDR_W | Loader memory address |
| dma_data_o | output | 8 | Loader memory write data |
| cpu_sel_i | input | 1 | Register port access strobe |
| cpu_we_i | input | 1 | Register port write (1) or read (0) |
| cpu_addr_i | input | ADDR_W | Register port address |
| cpu_wdata_i | input | 8 | Register port write data |
| cpu_rdata_o | output | 8 | Register port read data, registered |

## Verification
The bench sends a byte before the grant arrives. A loader that did not wait for the grant would store that byte at address zero and shift the whole image by one. It also sends a frame with a low stop bit. A receiver without a stop-bit check would write garbage, and the end of the load would then come one byte early. The bench checks that the bus request is still held just before the final byte and released just after it, and that address 255 is never written; an off-by-one terminal count shows up in either check. After the hand-off it checks that serial input no longer reaches memory, that a data read clears the ready flag, and that the transmitted frame is bit-exact, with transmitter-empty held low for the whole frame.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [1:0] {LD_REQ, LD_WAIT, LD_WRITE, LD_DONE} ld_state_t;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_BREAK} rx_state_t;
endpackage

// File: rtl/boot_uart_rx.sv
module boot_uart_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rx,
  output logic       valid,
  output logic [7:0] data
);
  import boot_pkg::*;
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rx_state_t      st;
  logic [1:0]     sync;
  logic [CW-1:0]  cnt;
  logic [2:0]     bitn;
  logic           rxs;

  assign rxs = sync[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync  <= 2'b11;
      st    <= RX_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      data  <= '0;
      valid <= 1'b0;
    end else begin
      sync  <= {sync[0], rx};
      valid <= 1'b0;
      if (tick) begin
        case (st)
          RX_IDLE: if (!rxs) begin st <= RX_START; cnt <= '0; end
          RX_START: begin
            cnt <= cnt + 1'b1;
            if (cnt == MID) begin
              cnt  <= '0;
              bitn <= '0;
              st   <= rxs ? RX_IDLE : RX_DATA;
            end
          end
          RX_DATA: begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              data <= {rxs, data[7:1]};
              bitn <= bitn + 1'b1;
              if (bitn == 3'd7) st <= RX_STOP;
            end
          end
          RX_STOP: begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              if (rxs) begin valid <= 1'b1; st <= RX_IDLE; end
              else st <= RX_BREAK;
            end
          end
          default: if (rxs) st <= RX_IDLE;
        endcase
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid); // R6
endmodule

// File: rtl/boot_uart_tx.sv
module boot_uart_tx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       start,
  input  logic [7:0] data,
  output logic       tx,
  output logic       busy
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [9:0]    sh;
  logic [3:0]    idx;
  logic [CW-1:0] cnt;

  assign tx = sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      idx  <= '0;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        sh   <= {1'b1, data, 1'b0};
        idx  <= '0;
        cnt  <= '0;
        busy <= 1'b1;
      end
    end else if (tick) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) begin
        sh  <= {1'b1, sh[9:1]};
        idx <= idx + 1'b1;
        if (idx == 4'd9) busy <= 1'b0;
      end
    end
  end

  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx); // R9
endmodule

// File: rtl/boot_dma_fsm.sv
module boot_dma_fsm #(
  parameter int ADDR_W     = 32,
  parameter int LOAD_BYTES = 255
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grant,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  output logic              req,
  output logic              drive,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        wdata,
  output logic              done
);
  import boot_pkg::*;
  localparam int CNT_W = $clog2(LOAD_BYTES + 1);
  localparam logic [CNT_W-1:0] END_CNT = CNT_W'(LOAD_BYTES - 1);

  ld_state_t        st;
  logic [CNT_W-1:0] cnt;

  assign req   = (st != LD_DONE);
  assign drive = (st == LD_WAIT) || (st == LD_WRITE);
  assign we    = (st == LD_WRITE);
  assign done  = (st == LD_DONE);
  assign addr  = ADDR_W'(cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= LD_REQ;
      cnt   <= '0;
      wdata <= '0;
    end else begin
      case (st)
        LD_REQ:  if (grant) st <= LD_WAIT;
        LD_WAIT: if (byte_valid) begin wdata <= byte_data; st <= LD_WRITE; end
        LD_WRITE: begin
          if (cnt == END_CNT) st <= LD_DONE;
          else begin cnt <= cnt + 1'b1; st <= LD_WAIT; end
        end
        default: st <= LD_DONE;
      endcase
    end
  end

  AST_DRIVE_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
    $rose(drive) |-> $past(grant)); // R1
  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    we |=> !we); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    ($fell(we) && drive) |-> (addr == $past(addr) + 1'b1)); // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && !req && !drive)); // R4
endmodule

// File: rtl/serial_boot_loader.sv
module serial_boot_loader #(
  parameter int          ADDR_W     = 32,
  parameter int          LOAD_BYTES = 255,
  parameter int          OVS_DIV    = 11,
  parameter logic [31:0] REG_BASE   = 32'hFFFF_F000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_i,
  output logic              tx_o,
  output logic              bus_req_o,
  input  logic              bus_grant_i,
  output logic              dma_drive_o,
  output logic              dma_as_o,
  output logic              dma_we_o,
  output logic [ADDR_W-1:0] dma_addr_o,
  output logic [7:0]        dma_data_o,
  input  logic              cpu_sel_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [7:0]        cpu_wdata_i,
  output logic [7:0]        cpu_rdata_o
);
  localparam int OVS  = 16;
  localparam int DV_W = (OVS_DIV > 1) ? $clog2(OVS_DIV) : 1;
  localparam logic [ADDR_W-1:0] DATA_ADR = ADDR_W'(REG_BASE);
  localparam logic [ADDR_W-1:0] STAT_ADR = ADDR_W'(REG_BASE + 32'd1);

  logic [DV_W-1:0] div_cnt;
  logic            tick;
  logic            rx_valid, tx_busy, ld_done, rx_ready;
  logic [7:0]      rx_byte, rx_hold;
  logic            rd_data, wr_data, rd_stat;

  generate
    if (OVS_DIV > 1) begin : g_div
      always_ff @(posedge clk) begin
        if (rst || div_cnt == DV_W'(OVS_DIV - 1)) div_cnt <= '0;
        else div_cnt <= div_cnt + 1'b1;
      end
      assign tick = (div_cnt == '0);
    end else begin : g_nodiv
      assign div_cnt = '0;
      assign tick    = 1'b1;
    end
  endgenerate

  boot_uart_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .rx(rx_i),
    .valid(rx_valid), .data(rx_byte));

  boot_uart_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .start(wr_data),
    .data(cpu_wdata_i), .tx(tx_o), .busy(tx_busy));

  boot_dma_fsm #(.ADDR_W(ADDR_W), .LOAD_BYTES(LOAD_BYTES)) u_fsm (
    .clk(clk), .rst(rst), .grant(bus_grant_i),
    .byte_valid(rx_valid), .byte_data(rx_byte),
    .req(bus_req_o), .drive(dma_drive_o), .we(dma_we_o),
    .addr(dma_addr_o), .wdata(dma_data_o), .done(ld_done));

  assign dma_as_o = dma_drive_o;
  assign rd_data  = cpu_sel_i && !cpu_we_i && cpu_addr_i == DATA_ADR;
  assign rd_stat  = cpu_sel_i && !cpu_we_i && cpu_addr_i == STAT_ADR;
  assign wr_data  = cpu_sel_i &&  cpu_we_i && cpu_addr_i == DATA_ADR;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_ready    <= 1'b0;
      rx_hold     <= '0;
      cpu_rdata_o <= '0;
    end else begin
      if (rd_data) begin
        cpu_rdata_o <= rx_hold;
        rx_ready    <= 1'b0;
      end else if (rd_stat) begin
        cpu_rdata_o <= {6'b0, rx_ready, !tx_busy};
      end
      if (rx_valid && ld_done) begin
        rx_hold  <= rx_byte;
        rx_ready <= 1'b1;
      end
    end
  end

  AST_NO_WRITE_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld_done |-> !dma_we_o); // R4
  AST_READ_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !(rx_valid && ld_done)) |=> !rx_ready); // R8
endmodule

// File: tb/serial_boot_loader_tb.sv
module serial_boot_loader_tb;
  localparam int DIV = 2;
  localparam int BIT = 16 * DIV;
  localparam int NB  = 255;

  logic clk = 0, rst = 1, rx = 1, grant = 0;
  logic sel = 0, we = 0;
  logic [31:0] caddr = 0;
  logic [7:0]  wdat = 0;
  logic tx, req, drive, as_o, dwe;
  logic [31:0] daddr;
  logic [7:0]  ddata, rdata;
  int checks = 0, errors = 0, writes = 0;
  logic [7:0] mem [256];

  always #2.5 clk = ~clk;

  serial_boot_loader #(.ADDR_W(32), .LOAD_BYTES(NB), .OVS_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .rx_i(rx), .tx_o(tx), .bus_req_o(req),
    .bus_grant_i(grant), .dma_drive_o(drive), .dma_as_o(as_o), .dma_we_o(dwe),
    .dma_addr_o(daddr), .dma_data_o(ddata), .cpu_sel_i(sel), .cpu_we_i(we),
    .cpu_addr_i(caddr), .cpu_wdata_i(wdat), .cpu_rdata_o(rdata));

  always @(posedge clk) if (!rst && dwe) begin
    writes <= writes + 1;
    if (daddr < 256) mem[daddr[7:0]] <= ddata;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic stopv);
    @(negedge clk) rx = 0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (BIT) @(negedge clk);
    end
    rx = stopv;
    repeat (BIT) @(negedge clk);
    rx = 1;
    if (!stopv) repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic cpu_read(input logic [31:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; we = 0; caddr = a;
    @(negedge clk); sel = 0; d = rdata;
  endtask

  task automatic cpu_write(input logic [31:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; we = 1; caddr = a; wdat = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7 + 3) & 8'hFF);
  endfunction

  task automatic t_reset;
    repeat (20) @(negedge clk);
    chk(req == 1, "R1 bus_req after reset", req, 1);
    chk(drive == 0 && as_o == 0 && dwe == 0, "R1 no drive before grant", drive, 0);
  endtask

  task automatic t_pregrant;
    send(8'hA5, 1'b1);
    repeat (10) @(negedge clk);
    chk(writes == 0, "R5 pre-grant byte not written", writes, 0);
    chk(drive == 0, "R1 still not driving", drive, 0);
    grant = 1;
    repeat (3) @(negedge clk);
    chk(drive == 1 && as_o == 1, "R2 drive after grant", drive, 1);
  endtask

  task automatic t_badstop;
    send(8'h3C, 1'b0);
    repeat (10) @(negedge clk);
    chk(writes == 0, "R6 bad stop frame discarded", writes, 0);
  endtask

  task automatic t_load;
    for (int i = 0; i < NB; i++) begin
      if (i == NB - 1) chk(req == 1, "R4 req held before last byte", req, 1);
      send(pat(i), 1'b1);
    end
    repeat (6) @(negedge clk);
    chk(writes == NB, "R2 one write per byte", writes, NB);
    chk(req == 0 && drive == 0 && as_o == 0, "R4 bus released", req, 0);
    chk(mem[0] == pat(0), "R3 first byte at address 0", mem[0], pat(0));
    chk(mem[1] == pat(1), "R3 second byte at address 1", mem[1], pat(1));
    chk(mem[NB-1] == pat(NB-1), "R3 last byte at address 254", mem[NB-1], pat(NB-1));
    begin
      int bad = 0;
      for (int i = 0; i < NB; i++) if (mem[i] != pat(i)) bad++;
      chk(bad == 0, "R3 whole image", bad, 0);
    end
    chk(mem[255] == 8'hEE, "R4 address 255 untouched", mem[255], 8'hEE);
    grant = 0;
  endtask

  task automatic t_postboot_rx;
    logic [7:0] d;
    cpu_read(32'hFFFFF001, d);
    chk(d == 8'h01, "R7 status after boot", d, 8'h01);
    send(8'h5A, 1'b1);
    repeat (6) @(negedge clk);
    chk(writes == NB && req == 0, "R4 serial input not loaded after hand-off", writes, NB);
    cpu_read(32'hFFFFF001, d);
    chk(d == 8'h03, "R7 rx ready set", d, 8'h03);
    cpu_read(32'hFFFFF000, d);
    chk(d == 8'h5A, "R7 received byte", d, 8'h5A);
    cpu_read(32'hFFFFF001, d);
    chk(d[1] == 0, "R8 read clears rx ready", d[1], 0);
  endtask

  task automatic t_tx(input logic [7:0] b);
    logic [7:0] d, got;
    logic startb, stopb;
    fork
      begin
        @(negedge tx);
        repeat (BIT / 2) @(negedge clk);
        startb = tx;
        for (int i = 0; i < 8; i++) begin
          repeat (BIT) @(negedge clk);
          got[i] = tx;
        end
        repeat (BIT) @(negedge clk);
        stopb = tx;
      end
      begin
        cpu_write(32'hFFFFF000, b);
        cpu_read(32'hFFFFF001, d);
        chk(d[0] == 0, "R9 tx empty cleared", d[0], 0);
        cpu_write(32'hFFFFF000, 8'hFF);
      end
    join
    chk(startb == 0 && stopb == 1, "R9 tx framing", {startb, stopb}, 1);
    chk(got == b, "R9 tx data", got, b);
    cpu_read(32'hFFFFF001, d);
    chk(d[0] == 0, "R9 tx empty held through stop bit", d[0], 0);
    repeat (BIT) @(negedge clk);
    cpu_read(32'hFFFFF001, d);
    chk(d[0] == 1, "R9 tx empty after frame", d[0], 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_pregrant();
    t_badstop();
    t_load();
    t_postboot_rx();
    t_tx(8'hC6);
    t_tx(8'h01);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule